// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block turns single core-side transfer requests into bus cycles on a shared 16-bit address/data bus with a 20-bit address. Each request names an address, direction, memory or I/O space, byte or word size, a segment tag and write data. The sequencer steps through the address phase, turnaround, data phases, optional wait phases and the closing phase. In each phase it drives the latch strobe, the read and write strobes, the transceiver controls, the space indicator, the byte-lane enables and a three-bit cycle-type code.

A word that starts on an odd address cannot use both lanes in one cycle. The block issues two byte cycles for it without help from the core and joins the two halves of read data. The core sees one acknowledge for each request and one done pulse when the last cycle ends. The pads themselves are not modelled: every driven bus group has its own output-enable, and read data arrives on a separate input.

Top module: `mbus_seq`

## Requirements
- R1: Every bus cycle runs through T1, T2, T3 and T4 in that order and lasts at least four clocks. `ale` is high for exactly the one T1 clock of each cycle and low in every other clock.
- R2: In T3 and in every wait clock (Tw), a low `rdy` adds one more Tw clock. The first T3 or Tw clock that sees `rdy` high is followed by T4. The active strobe stays low through every Tw clock.
- R3: `rd_n` is low in T2, T3 and Tw of a read cycle, and `wr_n` is low in the same phases of a write cycle. Both are high in all other clocks.
- R4: `den_n` is low from T2 through T4 on writes and from T3 through T4 on reads. `dt_r` is 1 during a write cycle and 0 otherwise. `m_io` is 1 during a memory cycle and 0 during I/O cycles and idle clocks.
- R5: `cyc_stat` carries the cycle code in T1, in T2, and in T3 or Tw while `rdy` is low. The codes are: I/O read 001, I/O write 010, code fetch 100 (a memory read with `req_fetch` set), memory read 101, memory write 110. In every other clock it is 111.
- R6: In T1, `bus_ad_out` carries address bits 15..0 with `bus_ad_oe` high. In T1, `bus_hi_out` carries address bits 19..16 for memory cycles and 0000 for I/O cycles. In T2 through T4, `bus_hi_out` is {2'b00, segment tag}. `bus_hi_oe` is high in T1 through T4 only.
- R7: Lane select {`bhe_n`, A0} is 00 for a whole word, 01 for the upper byte at an odd address, 10 for the lower byte at an even address, and 11 for none. Bits 7..0 carry even bytes and bits 15..8 carry odd bytes. `bhe_n` is 1 when idle.
- R8: A word request at an odd address A becomes two byte cycles. The first cycle moves the low byte at A on the upper lane. The second moves the high byte at A+1 (modulo 2^20) on the lower lane. No done pulse appears between the two cycles.
- R9: In T2 through T4 of a write, `bus_ad_out` carries the data on the selected lane(s) with `bus_ad_oe` high, and the unused lane is 0. For a byte request the byte is `req_wdata[7:0]`. In a read, `bus_ad_oe` is low after T1.
- R10: `rsp_done` is high for the T4 clock of the last cycle of a request. At that clock, a read returns `rsp_rdata`: the word {byte at A+1, byte at A}, or {8'h00, byte at A} for a byte request. Bytes are captured from the bus in the clock before T4.
- R11: `req_ack` is high only when `req_valid` is high and the block is idle or in the T4 of the last cycle of a request. The accepted request starts T1 on the next clock, so requests can run back to back with no idle clock.
- R12: While `rst` is high after a clock edge, the block is idle: strobes inactive, `ale` low, enables low, `cyc_stat` 111 and `rsp_done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request pending |
| req_ack | output | 1 | Request accepted this clock |
| req_addr | input | 20 | Byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| req_fetch | input | 1 | Memory read is a code fetch |
| req_word | input | 1 | 1 word, 0 byte |
| req_seg | input | 2 | Segment tag for the status lines |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Request finished |
| rsp_rdata | output | 16 | Read data |
| rdy | input | 1 | Device ready |
| bus_ad_in | input | 16 | Data sampled from the bus |
| bus_ad_out | output | 16 | Address/data driven onto the bus |
| bus_ad_oe | output | 1 | Enable for bus_ad_out |
| bus_hi_out | output | 4 | Upper address or segment status |
| bus_hi_oe | output | 1 | Enable for bus_hi_out |
| bhe_n | output | 1 | Upper lane enable, active low |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| dt_r | output | 1 | Transceiver direction, 1 transmit |
| m_io | output | 1 | Memory (1) or I/O (0) |
| cyc_stat | output | 3 | Cycle-type code |

## Verification
The bench uses the package defaults of a 20-bit address and a 16-bit data path. This puts the top-of-space case in reach: an odd word at FFFFF must wrap its second byte to 00000. The bench changes the ready pattern from always ready to every second, third and fourth clock. This gives zero, one and several wait clocks, including waits inside each half of a split word. The bench latches the address from the pins on every latch pulse and answers reads from a computed byte pattern, so wrong lanes or addresses show up in the returned data.

// File: rtl/mbus_pkg.sv
`timescale 1ns/1ps
package mbus_pkg;
    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;
    localparam int HI_W   = ADDR_W - DATA_W;
    localparam int SEG_W  = 2;
    localparam int STAT_W = 3;

    typedef enum logic [2:0] {
        PH_TI = 3'd0,
        PH_T1 = 3'd1,
        PH_T2 = 3'd2,
        PH_T3 = 3'd3,
        PH_TW = 3'd4,
        PH_T4 = 3'd5
    } phase_e;

    localparam logic [STAT_W-1:0] ST_IORD  = 3'b001;
    localparam logic [STAT_W-1:0] ST_IOWR  = 3'b010;
    localparam logic [STAT_W-1:0] ST_FETCH = 3'b100;
    localparam logic [STAT_W-1:0] ST_MEMRD = 3'b101;
    localparam logic [STAT_W-1:0] ST_MEMWR = 3'b110;
    localparam logic [STAT_W-1:0] ST_IDLE  = 3'b111;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              mem;
        logic              fetch;
        logic              word;
        logic [SEG_W-1:0]  seg;
        logic [DATA_W-1:0] wdata;
    } xreq_t;

    function automatic logic [STAT_W-1:0] stat_code(input logic write,
                                                   input logic mem,
                                                   input logic fetch);
        if (!mem)       return write ? ST_IOWR : ST_IORD;
        else if (write) return ST_MEMWR;
        else            return fetch ? ST_FETCH : ST_MEMRD;
    endfunction

    function automatic logic data_wait(input phase_e p);
        return (p == PH_T3) || (p == PH_TW);
    endfunction
endpackage

// File: rtl/mbus_tstate.sv
`timescale 1ns/1ps
module mbus_tstate
    import mbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   more,
    input  logic   rdy,
    output phase_e phase
);
    phase_e nxt;

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_TI:        nxt = start ? PH_T1 : PH_TI;
            PH_T1:        nxt = PH_T2;
            PH_T2:        nxt = PH_T3;
            PH_T3, PH_TW: nxt = rdy ? PH_T4 : PH_TW;
            PH_T4:        nxt = (more || start) ? PH_T1 : PH_TI;
            default:      nxt = PH_TI;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_TI;
        else     phase <= nxt;
    end

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (data_wait(phase) && !rdy) |=> (phase == PH_TW)); // R2
    AST_T1_TO_T2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T1) |=> (phase == PH_T2)); // R1
    AST_READY_ENDS: assert property (@(posedge clk) disable iff (rst)
        (data_wait(phase) && rdy) |=> (phase == PH_T4)); // R2
endmodule

// File: rtl/mbus_xfer.sv
`timescale 1ns/1ps
module mbus_xfer
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  xreq_t             req_in,
    input  phase_e            phase,
    input  logic              rdy,
    input  logic [DATA_W-1:0] bus_in,
    output logic              cur_write,
    output logic              cur_mem,
    output logic              cur_fetch,
    output logic [SEG_W-1:0]  cur_seg,
    output logic              more,
    output logic [ADDR_W-1:0] sub_addr,
    output logic              lane_bhe_n,
    output logic [DATA_W-1:0] lane_wdata,
    output logic [DATA_W-1:0] rdata
);
    xreq_t             cur;
    logic              sub;
    logic              split;
    logic              full;
    logic [BYTE_W-1:0] wbyte;
    logic [BYTE_W-1:0] pick;
    logic              take;

    assign split     = cur.word & cur.addr[0];
    assign full      = cur.word & ~cur.addr[0];
    assign more      = split & ~sub;
    assign sub_addr  = sub ? cur.addr + ADDR_W'(1) : cur.addr;
    assign cur_write = cur.write;
    assign cur_mem   = cur.mem;
    assign cur_fetch = cur.fetch;
    assign cur_seg   = cur.seg;

    // Upper lane whenever the byte address is odd; both lanes for an aligned word.
    assign lane_bhe_n = ~(sub_addr[0] | full);

    always_comb begin
        wbyte = (split && sub) ? cur.wdata[DATA_W-1:BYTE_W] : cur.wdata[BYTE_W-1:0];
        if (full)             lane_wdata = cur.wdata;
        else if (sub_addr[0]) lane_wdata = {wbyte, {BYTE_W{1'b0}}};
        else                  lane_wdata = {{BYTE_W{1'b0}}, wbyte};
    end

    assign pick = sub_addr[0] ? bus_in[DATA_W-1:BYTE_W] : bus_in[BYTE_W-1:0];
    assign take = data_wait(phase) && rdy && !cur.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '0;
            sub   <= 1'b0;
            rdata <= '0;
        end else begin
            if (accept) begin
                cur <= req_in;
                sub <= 1'b0;
            end else if (phase == PH_T4 && more) begin
                sub <= 1'b1;
            end
            if (take) begin
                if (full)             rdata <= bus_in;
                else if (split & sub) rdata[DATA_W-1:BYTE_W] <= pick;
                else                  rdata <= {{BYTE_W{1'b0}}, pick};
            end
        end
    end

    AST_SECOND_HALF_EVEN: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T4 && more) |=> (!sub_addr[0] && lane_bhe_n)); // R8
endmodule

// File: rtl/mbus_drive.sv
`timescale 1ns/1ps
module mbus_drive
    import mbus_pkg::*;
(
    input  phase_e            phase,
    input  logic              write,
    input  logic              mem,
    input  logic              fetch,
    input  logic [SEG_W-1:0]  seg,
    input  logic [ADDR_W-1:0] sub_addr,
    input  logic              lane_bhe_n,
    input  logic [DATA_W-1:0] lane_wdata,
    input  logic              rdy,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [HI_W-1:0]   hi_out,
    output logic              hi_oe,
    output logic              bhe_n,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              dt_r,
    output logic              m_io,
    output logic [STAT_W-1:0] stat
);
    logic busy, addr_ph, strobe_ph, data_ph, show_code;

    assign busy      = (phase != PH_TI);
    assign addr_ph   = (phase == PH_T1);
    assign strobe_ph = (phase == PH_T2) || data_wait(phase);
    assign data_ph   = strobe_ph || (phase == PH_T4);
    assign show_code = addr_ph || (phase == PH_T2) || (data_wait(phase) && !rdy);

    assign ale   = addr_ph;
    assign rd_n  = ~(strobe_ph & ~write);
    assign wr_n  = ~(strobe_ph & write);
    assign den_n = write ? ~data_ph : ~(data_wait(phase) || phase == PH_T4);
    assign dt_r  = busy & write;
    assign m_io  = busy & mem;
    assign bhe_n = busy ? lane_bhe_n : 1'b1;
    assign stat  = show_code ? stat_code(write, mem, fetch) : ST_IDLE;
    assign hi_oe = busy;

    always_comb begin
        if (addr_ph)      hi_out = mem ? sub_addr[ADDR_W-1:DATA_W] : '0;
        else if (data_ph) hi_out = HI_W'(seg);
        else              hi_out = '0;
    end

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        if (addr_ph) begin
            ad_out = sub_addr[DATA_W-1:0];
            ad_oe  = 1'b1;
        end else if (data_ph && write) begin
            ad_out = lane_wdata;
            ad_oe  = 1'b1;
        end
    end
endmodule

// File: rtl/mbus_seq.sv
`timescale 1ns/1ps
module mbus_seq
    import mbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ack,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic              req_fetch,
    input  logic              req_word,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              rdy,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic [HI_W-1:0]   bus_hi_out,
    output logic              bus_hi_oe,
    output logic              bhe_n,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic              den_n,
    output logic              dt_r,
    output logic              m_io,
    output logic [STAT_W-1:0] cyc_stat
);
    phase_e            phase;
    xreq_t             req_in;
    logic              more;
    logic              cur_write, cur_mem, cur_fetch;
    logic [SEG_W-1:0]  cur_seg;
    logic [ADDR_W-1:0] sub_addr;
    logic              lane_bhe_n;
    logic [DATA_W-1:0] lane_wdata;
    logic              last_t4;

    assign req_in   = '{addr: req_addr, write: req_write, mem: req_mem, fetch: req_fetch,
                        word: req_word, seg: req_seg, wdata: req_wdata};
    assign last_t4  = (phase == PH_T4) && !more;
    assign req_ack  = req_valid && ((phase == PH_TI) || last_t4);
    assign rsp_done = last_t4;

    mbus_tstate u_tstate (
        .clk(clk), .rst(rst), .start(req_ack), .more(more), .rdy(rdy), .phase(phase)
    );

    mbus_xfer u_xfer (
        .clk(clk), .rst(rst), .accept(req_ack), .req_in(req_in), .phase(phase),
        .rdy(rdy), .bus_in(bus_ad_in), .cur_write(cur_write), .cur_mem(cur_mem),
        .cur_fetch(cur_fetch), .cur_seg(cur_seg), .more(more), .sub_addr(sub_addr),
        .lane_bhe_n(lane_bhe_n), .lane_wdata(lane_wdata), .rdata(rsp_rdata)
    );

    mbus_drive u_drive (
        .phase(phase), .write(cur_write), .mem(cur_mem), .fetch(cur_fetch),
        .seg(cur_seg), .sub_addr(sub_addr), .lane_bhe_n(lane_bhe_n),
        .lane_wdata(lane_wdata), .rdy(rdy), .ad_out(bus_ad_out), .ad_oe(bus_ad_oe),
        .hi_out(bus_hi_out), .hi_oe(bus_hi_oe), .bhe_n(bhe_n), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dt_r(dt_r), .m_io(m_io),
        .stat(cyc_stat)
    );

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale); // R1
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n)); // R3
    AST_ACK_STARTS_T1: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> ale); // R11
    AST_PASSIVE_AT_T4: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (cyc_stat == ST_IDLE)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R10
    AST_NO_STROBE_AT_ALE: assert property (@(posedge clk) disable iff (rst)
        ale |-> (rd_n && wr_n)); // R3
endmodule

// File: tb/mbus_seq_test.sv
`timescale 1ns/1ps
module mbus_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ack;
    logic [19:0] req_addr;
    logic        req_write, req_mem, req_fetch, req_word;
    logic [1:0]  req_seg;
    logic [15:0] req_wdata;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        rdy;
    logic [15:0] bus_ad_in, bus_ad_out;
    logic        bus_ad_oe;
    logic [3:0]  bus_hi_out;
    logic        bus_hi_oe, bhe_n, ale, rd_n, wr_n, den_n, dt_r, m_io;
    logic [2:0]  cyc_stat;

    always #5 clk = ~clk;

    mbus_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ack(req_ack),
        .req_addr(req_addr), .req_write(req_write), .req_mem(req_mem),
        .req_fetch(req_fetch), .req_word(req_word), .req_seg(req_seg),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .rdy(rdy), .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out),
        .bus_ad_oe(bus_ad_oe), .bus_hi_out(bus_hi_out), .bus_hi_oe(bus_hi_oe),
        .bhe_n(bhe_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n),
        .dt_r(dt_r), .m_io(m_io), .cyc_stat(cyc_stat)
    );

    typedef struct {
        logic [19:0] a;
        logic        w, m, f, wd;
        logic [1:0]  s;
        logic [15:0] d;
    } breq_t;

    breq_t       q[$];
    breq_t       cur;
    int          m_ph;      // 0 idle, 1 T1, 2 T2, 3 T3, 4 Tw, 5 T4
    bit          m_sub;
    int          errors = 0, checks = 0;
    int          rdy_div = 0, cnt = 0;
    logic [19:0] la = '0;
    bit          finished = 0;

    function automatic logic [7:0] mb(input logic [19:0] a);
        logic [7:0] v;
        v = a[7:0] * 8'd13;
        return v ^ a[15:8] ^ {4'h0, a[19:16]} ^ 8'hA5;
    endfunction

    function automatic logic [19:0] pa(input logic [19:0] x, input logic m);
        return m ? x : {4'h0, x[15:0]};
    endfunction

    assign bus_ad_in = {mb({la[19:1], 1'b1}), mb({la[19:1], 1'b0})};

    function automatic bit is_split();
        return cur.wd && cur.a[0];
    endfunction

    function automatic bit last_sub();
        return !(is_split() && !m_sub);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Reference model: advances one phase per clock
    always @(posedge clk) begin
        bit ackx;
        ackx = req_valid && (m_ph == 0 || (m_ph == 5 && last_sub()));
        if (rst) begin
            m_ph  = 0;
            m_sub = 0;
        end else begin
            case (m_ph)
                1: m_ph = 2;
                2: m_ph = 3;
                3, 4: m_ph = rdy ? 5 : 4;
                default: begin
                    if (m_ph == 5 && !last_sub()) begin
                        m_sub = 1;
                        m_ph  = 1;
                    end else if (ackx) begin
                        cur   = q.pop_front();
                        m_sub = 0;
                        m_ph  = 1;
                    end else begin
                        m_ph = 0;
                    end
                end
            endcase
        end
    end

    task automatic compare();
        logic [19:0] sa;
        logic [15:0] ed;
        logic [7:0]  b;
        logic [3:0]  eh;
        logic [2:0]  code;
        bit busy, t1, strb, late, w, edone;
        sa   = m_sub ? cur.a + 20'd1 : cur.a;
        busy = (m_ph != 0);
        t1   = (m_ph == 1);
        strb = (m_ph >= 2 && m_ph <= 4);
        late = (m_ph >= 2 && m_ph <= 5);
        w    = cur.w;
        chk("R1 ale", ale, t1);
        chk("R3 rd_n", rd_n, !(strb && !w));
        chk("R3 wr_n", wr_n, !(strb && w));
        if (m_ph == 4) chk("R2 strobe held in Tw", rd_n && wr_n, 1'b0);
        chk("R4 den_n", den_n, w ? !late : !(m_ph >= 3 && m_ph <= 5));
        chk("R4 dt_r", dt_r, busy && w);
        chk("R4 m_io", m_io, busy && cur.m);
        code = !cur.m ? (w ? 3'b010 : 3'b001) : (w ? 3'b110 : (cur.f ? 3'b100 : 3'b101));
        chk("R5 cyc_stat", cyc_stat,
            (t1 || m_ph == 2 || ((m_ph == 3 || m_ph == 4) && !rdy)) ? code : 3'b111);
        eh = t1 ? (cur.m ? sa[19:16] : 4'h0) : (late ? {2'b00, cur.s} : 4'h0);
        chk("R6 upper lines", {bus_hi_oe, bus_hi_out}, {busy, eh});
        chk("R7 bhe_n", bhe_n, !busy ? 1'b1 : ((cur.wd && !cur.a[0]) ? 1'b0 : !sa[0]));
        if (t1) begin
            chk("R6 address phase", {bus_ad_oe, bus_ad_out}, {1'b1, sa[15:0]});
            if (is_split()) chk("R8 split lane", {bhe_n, bus_ad_out[0]}, m_sub ? 2'b10 : 2'b01);
        end else begin
            if (cur.wd && !cur.a[0]) ed = cur.d;
            else begin
                b  = (is_split() && m_sub) ? cur.d[15:8] : cur.d[7:0];
                ed = sa[0] ? {b, 8'h00} : {8'h00, b};
            end
            if (late && w) chk("R9 write data", {bus_ad_oe, bus_ad_out}, {1'b1, ed});
            else           chk("R9 bus released", {bus_ad_oe, bus_ad_out}, {1'b0, 16'h0});
        end
        chk("R11 req_ack", req_ack, req_valid && (m_ph == 0 || (m_ph == 5 && last_sub())));
        edone = (m_ph == 5) && last_sub();
        if (m_ph == 5 && !last_sub()) chk("R8 no early done", rsp_done, 1'b0);
        else                          chk("R10 rsp_done", rsp_done, edone);
        if (edone && !w)
            chk("R10 read data", rsp_rdata,
                cur.wd ? {mb(pa(cur.a + 20'd1, cur.m)), mb(pa(cur.a, cur.m))}
                       : {8'h00, mb(pa(cur.a, cur.m))});
        if (ale) la = {bus_hi_out, bus_ad_out};
    endtask

    task automatic step();
        @(negedge clk);
        cnt++;
        rdy = (rdy_div == 0) ? 1'b1 : ((cnt % rdy_div) == 0);
        if (q.size() > 0) begin
            req_valid = 1'b1;
            req_addr  = q[0].a;  req_write = q[0].w; req_mem  = q[0].m;
            req_fetch = q[0].f;  req_word  = q[0].wd; req_seg = q[0].s;
            req_wdata = q[0].d;
        end else begin
            req_valid = 1'b0;
        end
        #1;
        compare();
    endtask

    task automatic push(input logic [19:0] a, input logic w, input logic m, input logic f,
                        input logic wd, input logic [1:0] s, input logic [15:0] d);
        breq_t r;
        r.a = a; r.w = w; r.m = m; r.f = f; r.wd = wd; r.s = s; r.d = d;
        q.push_back(r);
    endtask

    task automatic drain();
        for (int g = 0; g < 3000 && (q.size() > 0 || m_ph != 0); g++) step();
        step();
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; rdy = 1'b1;
        req_addr = '0; req_write = 0; req_mem = 0; req_fetch = 0; req_word = 0;
        req_seg = '0; req_wdata = '0;
        cur = '{a: '0, w: 0, m: 0, f: 0, wd: 0, s: '0, d: '0};
        m_ph = 0; m_sub = 0;
        repeat (3) begin
            @(negedge clk); #1;
            chk("R12 reset strobes", {ale, rd_n, wr_n, den_n}, 4'b0111);
            chk("R12 reset status", cyc_stat, 3'b111);
            chk("R12 reset enables", {bus_ad_oe, bus_hi_oe, rsp_done, req_ack}, 4'b0000);
        end
        rst = 1'b0;

        // aligned accesses, no waits, back to back
        rdy_div = 0;
        push(20'h12344, 0, 1, 0, 1, 2'b11, 16'h0000);
        push(20'hA0010, 1, 1, 0, 1, 2'b01, 16'hBEEF);
        push(20'h00123, 0, 1, 0, 0, 2'b11, 16'h0000);
        push(20'h00456, 0, 1, 0, 0, 2'b00, 16'h0000);
        push(20'h00777, 1, 1, 0, 0, 2'b11, 16'h99C3);
        push(20'h00778, 1, 1, 0, 0, 2'b11, 16'h775A);
        drain();

        // split words, I/O space and fetch with waits
        rdy_div = 3;
        push(20'h2345B, 0, 1, 0, 1, 2'b11, 16'h0000);
        push(20'h0FFF1, 1, 1, 0, 1, 2'b01, 16'h1234);
        push(20'hF8002, 0, 0, 0, 1, 2'b11, 16'h0000);
        push(20'h30081, 1, 0, 0, 0, 2'b11, 16'h00A7);
        push(20'h40000, 0, 1, 1, 1, 2'b10, 16'h0000);
        push(20'h50007, 0, 0, 1, 1, 2'b11, 16'h0000);
        drain();

        // top-of-space wrap
        rdy_div = 2;
        push(20'hFFFFF, 0, 1, 0, 1, 2'b11, 16'h0000);
        push(20'hFFFFF, 1, 1, 0, 1, 2'b11, 16'hC0DE);
        drain();

        // isolated requests with longer waits
        rdy_div = 4;
        push(20'h6A5A1, 0, 1, 0, 0, 2'b01, 16'h0000);
        drain();
        push(20'h7B3C2, 1, 0, 0, 1, 2'b00, 16'h5AA5);
        drain();
        push(20'h8C4D3, 1, 1, 0, 1, 2'b10, 16'hF00D);
        drain();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule